// File: doc/BRIEF.md
# Long-Interval Absolute-Time Pulse Generator

This block drives a single output pin high and then low at two absolute times chosen by software. The pulse can last from seconds to tens of minutes. A prescaler divides the system clock into a loop period. Once per loop period a wide free-running tick counter steps forward, and the turn-on and turn-off comparisons are made against it. The counter is built from two equal halves joined by a carry, and a match never resets it. Every time software programs is therefore an absolute position on that one timeline.

Software loads each 2×HALF_W-bit time as a high word and a low word through a plain write port. A high-word write is only staged. The pair takes effect when the low word is written, so a comparison never sees a half-written time. A sticky flag reports that the turn-off point has been passed. Software clears it by writing one, then schedules the next pulse.

Top module: `abs_pulse_timer`

## Requirements
- R1: An internal loop tick occurs once every LOOP_CLKS clocks. The first tick falls on the LOOP_CLKS-th rising edge after reset is released. The tick counter increments by one on each tick and holds its value at all other times.
- R2: The counter is two HALF_W-bit halves. The upper half adds the carry out of the lower half, so the counter passes from low-half all-ones into the next upper value.
- R3: The write decode is: address 0 is the on-time high word, 1 the on-time low word, 2 the off-time high word, 3 the off-time low word, and 4 the status register, whose bit 0 is the off flag. Data width is HALF_W.
- R4: On a tick where the counter value before the increment equals the active on-time, with both halves equal, the pin becomes 1 at that same clock edge. For time T this is rising edge (T+1)·LOOP_CLKS after reset.
- R5: On a tick where the counter equals the active off-time, the pin becomes 0. The on check is ordered before the off check, so when both times equal the counter, the pin ends at 0.
- R6: A match does not reset the counter, so later events occur at their absolute times measured from reset.
- R7: The off flag is set by an off-time match and stays set. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: Synchronous reset drives the pin to 0, the flag to 0 and the counter to 0, and sets both times to all-ones.
- R9: Writing a high word alone does not change the active time that is compared. The staged high word is applied together with the next low-word write to the same time.
- R10: A low-half equality while the upper halves differ causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | HALF_W | Write data |
| pulse_out | output | 1 | Generated pulse pin |
| off_event_flag | output | 1 | Sticky turn-off event flag |

## Verification
The case hardest to reach from the ports is a time whose upper half is non-zero. To get there the low half must roll over, which at the default sizes takes 2^32 loop periods. The bench therefore builds the block with an 8-bit half and a 4-clock loop. This lets the counter cross into upper values 1, 2 and 3 within a few thousand clocks. Along the way it also places an on-time whose low half is passed while the upper half is still zero, to show that no event fires on that partial match.

// File: rtl/apt_pkg.sv
package apt_pkg;
  typedef enum logic [2:0] {
    ADDR_ON_HI  = 3'd0,
    ADDR_ON_LO  = 3'd1,
    ADDR_OFF_HI = 3'd2,
    ADDR_OFF_LO = 3'd3,
    ADDR_STATUS = 3'd4
  } apt_addr_e;

  localparam int STATUS_CLR_BIT = 0;
endpackage

// File: rtl/apt_loop_tick.sv
module apt_loop_tick #(
  parameter int LOOP_CLKS = 128
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (LOOP_CLKS > 1) ? $clog2(LOOP_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(LOOP_CLKS - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  generate
    if (LOOP_CLKS > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/apt_split_counter.sv
module apt_split_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi
);
  logic lo_carry;

  function automatic logic [HALF_W:0] inc_half(input logic [HALF_W-1:0] v);
    return {1'b0, v} + 1'b1;
  endfunction

  logic [HALF_W-1:0] lo_next;
  assign {lo_carry, lo_next} = inc_half(cnt_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (step) begin
      cnt_lo <= lo_next;
      cnt_hi <= cnt_hi + HALF_W'(lo_carry);
    end
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R1
  AST_LO_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !(&cnt_lo)) |=> (cnt_lo == $past(cnt_lo) + 1'b1) && $stable(cnt_hi)); // R1
  AST_CARRY_INTO_HI: assert property (@(posedge clk) disable iff (rst)
    (step && (&cnt_lo)) |=> (cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + 1'b1)); // R2
endmodule

// File: rtl/apt_time_reg.sv
module apt_time_reg #(
  parameter int          HALF_W  = 32,
  parameter logic [2:0]  HI_ADDR = 3'd0,
  parameter logic [2:0]  LO_ADDR = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] cnt_hi,
  output logic              hit
);
  logic [HALF_W-1:0] staged_hi;
  logic [HALF_W-1:0] act_hi;
  logic [HALF_W-1:0] act_lo;
  logic              hi_wr;
  logic              lo_wr;
  logic              hi_eq;

  assign hi_wr = wr_en && (wr_addr == HI_ADDR);
  assign lo_wr = wr_en && (wr_addr == LO_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_hi <= '1;
      act_hi    <= '1;
      act_lo    <= '1;
    end else begin
      if (hi_wr) staged_hi <= wr_data;
      if (lo_wr) begin
        act_hi <= staged_hi;
        act_lo <= wr_data;
      end
    end
  end

  // upper word decides first, lower word only matters once it agrees
  assign hi_eq = (act_hi == cnt_hi);
  assign hit   = hi_eq && (act_lo == cnt_lo);

  AST_HI_STAGED: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> ($stable(act_hi) && $stable(act_lo))); // R9
  AST_HI_GATES: assert property (@(posedge clk) disable iff (rst)
    (act_hi != cnt_hi) |-> !hit); // R10
endmodule

// File: rtl/abs_pulse_timer.sv
module abs_pulse_timer #(
  parameter int HALF_W    = 32,
  parameter int LOOP_CLKS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic              pulse_out,
  output logic              off_event_flag
);
  import apt_pkg::*;

  localparam int NUM_TIMES = 2;
  localparam int IDX_ON    = 0;
  localparam int IDX_OFF   = 1;

  logic              loop_tick;
  logic [HALF_W-1:0] cnt_lo;
  logic [HALF_W-1:0] cnt_hi;
  logic [NUM_TIMES-1:0] time_hit;
  logic              on_hit;
  logic              off_hit;
  logic              flag_clr;

  apt_loop_tick #(.LOOP_CLKS(LOOP_CLKS)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(loop_tick)
  );

  apt_split_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (loop_tick),
    .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi)
  );

  generate
    for (genvar g = 0; g < NUM_TIMES; g++) begin : g_time
      apt_time_reg #(
        .HALF_W (HALF_W),
        .HI_ADDR(3'(2 * g)),
        .LO_ADDR(3'(2 * g + 1))
      ) u_time (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .hit    (time_hit[g])
      );
    end
  endgenerate

  assign on_hit   = loop_tick && time_hit[IDX_ON];
  assign off_hit  = loop_tick && time_hit[IDX_OFF];
  assign flag_clr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[STATUS_CLR_BIT];

  // on check first, off check second: the later one decides
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b0;
    end else if (off_hit) begin
      pulse_out <= 1'b0;
    end else if (on_hit) begin
      pulse_out <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           off_event_flag <= 1'b0;
    else if (off_hit)  off_event_flag <= 1'b1;
    else if (flag_clr) off_event_flag <= 1'b0;
  end

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !loop_tick |=> $stable(pulse_out)); // R1
  AST_ON_SETS: assert property (@(posedge clk) disable iff (rst)
    (on_hit && !off_hit) |=> pulse_out); // R4
  AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    off_hit |=> !pulse_out); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (off_event_flag && !flag_clr) |=> off_event_flag); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    off_hit |=> off_event_flag); // R7
  AST_NO_PHANTOM_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> $past(on_hit)); // R4
endmodule

// File: tb/abs_pulse_timer_test.sv
module abs_pulse_timer_test;
  localparam int HW = 8;
  localparam int LC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [HW-1:0] wr_data = '0;
  logic          pulse_out;
  logic          off_event_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  abs_pulse_timer #(.HALF_W(HW), .LOOP_CLKS(LC)) uut (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .pulse_out     (pulse_out),
    .off_event_flag(off_event_flag)
  );

  // event for absolute time t lands on edge (t+1)*LC after reset
  function automatic int edge_of(input int t);
    return (t + 1) * LC;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_times(input int on_t, input int off_t);
    wr(3'd0, HW'(on_t >> HW));
    wr(3'd1, HW'(on_t));
    wr(3'd2, HW'(off_t >> HW));
    wr(3'd3, HW'(off_t));
  endtask

  task automatic at_cyc(input int n);
    while (cyc < n) @(negedge clk);
    if (cyc != n) begin
      fails++;
      $display("FAIL scheduling: actual cycle %0d expected %0d", cyc, n);
    end
  endtask

  task automatic clear_flag();
    wr(3'd4, HW'(1));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R8 pin in reset", pulse_out, 0);
    chk("R8 flag in reset", off_event_flag, 0);
    rst = 1'b0;
  endtask

  task automatic test_basic();
    program_times(10, 20);                    // R3 addresses 0..3
    at_cyc(edge_of(10) - 1); chk("R1 R4 pin before on", pulse_out, 0);
    at_cyc(edge_of(10));     chk("R4 pin after on", pulse_out, 1);
    at_cyc(edge_of(20) - 1); chk("R5 pin before off", pulse_out, 1);
                             chk("R7 flag before off", off_event_flag, 0);
    at_cyc(edge_of(20));     chk("R5 pin after off", pulse_out, 0);
                             chk("R7 flag set", off_event_flag, 1);
    wr(3'd4, HW'(0));        chk("R7 write zero keeps flag", off_event_flag, 1);
    clear_flag();            chk("R7 write one clears flag", off_event_flag, 0);
  endtask

  task automatic test_staging();
    program_times(30, 40);
    wr(3'd0, HW'(1));        // staged only, must not move the on time
    at_cyc(edge_of(30) - 1); chk("R9 pin before on", pulse_out, 0);
    at_cyc(edge_of(30));     chk("R9 R6 on at absolute time", pulse_out, 1);
    at_cyc(edge_of(40));     chk("R6 off at absolute time", pulse_out, 0);
    clear_flag();
  endtask

  task automatic test_equal();
    program_times(50, 50);
    at_cyc(edge_of(50) - 1); chk("R7 flag clear before", off_event_flag, 0);
    at_cyc(edge_of(50));     chk("R5 equal times leave pin low", pulse_out, 0);
                             chk("R5 equal times set flag", off_event_flag, 1);
    clear_flag();
  endtask

  task automatic test_hiword();
    program_times('h13C, 'h150);
    at_cyc(edge_of('h3C));   chk("R10 low half alone no event", pulse_out, 0);
    at_cyc(edge_of('h13C) - 1); chk("R2 pin before carried on", pulse_out, 0);
    at_cyc(edge_of('h13C));  chk("R2 R4 pin on past carry", pulse_out, 1);
    at_cyc(edge_of('h150));  chk("R5 pin off upper half 1", pulse_out, 0);
    clear_flag();
  endtask

  task automatic test_carry();
    program_times('h200, 'h202);
    at_cyc(edge_of('h200) - 1); chk("R2 pin before rollover on", pulse_out, 0);
    at_cyc(edge_of('h200));  chk("R2 pin at rollover on", pulse_out, 1);
    at_cyc(edge_of('h202));  chk("R5 pin off after rollover", pulse_out, 0);
    clear_flag();
  endtask

  task automatic test_reset_mid();
    program_times('h300, 'h310);
    at_cyc(edge_of('h300));  chk("R4 pin high before reset", pulse_out, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 pin cleared by reset", pulse_out, 0);
    chk("R8 flag cleared by reset", off_event_flag, 0);
    rst = 1'b0;
    program_times(5, 7);
    at_cyc(edge_of(5) - 1);  chk("R8 counter restarted, before", pulse_out, 0);
    at_cyc(edge_of(5));      chk("R8 counter restarted, on", pulse_out, 1);
    at_cyc(edge_of(7));      chk("R8 off after restart", pulse_out, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    test_basic();
    test_staging();
    test_equal();
    test_hiword();
    test_carry();
    test_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule